// File: doc/BRIEF.md
# I2C Master Register Front-End

This block is the software-facing side of an I2C master. A processor reaches it over a simple byte/halfword register bus with five registers: own address, clock divider, control, status and data. Each register access that needs the I2C bus becomes one byte-level request to a separate I2C engine, which handles the bit timing. The request is one of start-with-address, send byte, receive byte or stop. The engine answers each request with an acknowledge and a nack flag. While a request is outstanding, the register bus is held off by a low ready signal.

Software alone drives the progress of a transfer. With master mode on and no transfer open, a data write carries the address byte. Later data writes send payload bytes. In receive direction, each data read fetches the next byte. A nack on a payload byte closes the transfer, and so does clearing master mode or requesting a repeated start. Completed operations set an interrupt flag if interrupts are enabled. Software clears the flag by writing zero to it. Clearing the enable bit while the block is enabled is a soft reset.

Top module: `i2cm_ctrl_front`

## Requirements
- R1: Register offsets are 0x00 own address (bits 7:1 kept, bit 0 reads 0), 0x04 divider (bits 5:0 kept), 0x08 control, 0x0C status and 0x10 data. Write data is cut to its low 8 bits and read data bits 15:8 are 0. Any other offset reads 0 and ignores writes.
- R2: After reset, every register reads 0, irq is low, eng_req is low and bus_ready is high for register accesses.
- R3: The control bits are 7 enable, 6 interrupt enable, 5 master, 4 transmit, 3 no-ack (stored only) and 2 repeated start; bits 1:0 read 0. The status bits are 0 received-nack, 1 interrupt flag and 5 bus busy. A normal control write copies its master bit into bus busy.
- R4: A control write with bit 7 = 0 while the block is enabled is a soft reset. Every register except own address returns to 0 and any open transfer is closed. If a transfer was open, a STOP request goes out first.
- R5: A data write with enable = 1, master = 1 and no transfer open issues START (op 0) with the written byte (bits 7:1 address, bit 0 direction). An ack clears received-nack, opens the transfer and raises the flag. A nack sets received-nack and leaves the transfer closed.
- R6: A data write with a transfer open issues SEND (op 1). An ack clears received-nack and raises the flag. A nack sets received-nack and closes the transfer without a STOP request.
- R7: A data read in master mode with a transfer open and transmit = 0 issues RECV (op 2) and returns the received byte, or 0xFF on a nack with no flag raised. In master mode otherwise, the read returns 0xFF and issues no request.
- R8: The interrupt flag is set only when enable and interrupt enable are both 1. The irq output equals the flag.
- R9: Writing 0 to status bit 1 clears the flag and irq. Writing 1 to it leaves the flag unchanged.
- R10: A control write with master = 0 while a transfer is open issues STOP (op 3), closes the transfer and clears bus busy.
- R11: A control write with repeated start = 1 while a transfer is open issues STOP, closes the transfer and stores bit 2 as 0. With no transfer open, bit 2 is stored as written.
- R12: While enable = 0, data writes issue no request and change no state.
- R13: eng_req stays high with stable eng_op and eng_wbyte until eng_ack. bus_ready stays low until that acknowledge completes the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access valid; held until bus_ready |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | DW | Write data (low 8 bits used) |
| bus_rdata | output | DW | Read data |
| bus_ready | output | 1 | Access completes in a cycle with bus_sel and bus_ready high |
| irq | output | 1 | Interrupt, equal to the status flag |
| eng_req | output | 1 | Request to the byte engine |
| eng_op | output | 2 | 0 START, 1 SEND, 2 RECV, 3 STOP |
| eng_wbyte | output | 8 | Address or data byte for START/SEND |
| eng_ack | input | 1 | One-cycle completion from the engine |
| eng_nack | input | 1 | Nack or failure, valid with eng_ack |
| eng_rbyte | input | 8 | Received byte, valid with eng_ack |

## Verification
The bench tracks whether a transfer is open by the opcode of the next request. A design that failed to close the transfer on a payload nack or a master clear would send SEND where START is expected. Repeated start is checked both with a transfer open and with none open, so a design that always self-clears bit 2 is caught. The soft-reset test leaves the flag, the divider and an open transfer in place beforehand, so a design that also wiped own address or skipped the STOP shows a wrong readback or a missing request. Reads with the transmit bit set, and data writes while disabled, must leave the request count unchanged; a design that leaks an engine request in either case shows up in that count.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_SEND  = 2'd1,
    OP_RECV  = 2'd2,
    OP_STOP  = 2'd3
  } eng_op_e;

  localparam int NREG       = 5;
  localparam int OFF_STRIDE = 4;

  localparam int IX_OWN = 0;
  localparam int IX_DIV = 1;
  localparam int IX_CTL = 2;
  localparam int IX_STS = 3;
  localparam int IX_DAT = 4;

  localparam int CB_EN    = 7;
  localparam int CB_IE    = 6;
  localparam int CB_MST   = 5;
  localparam int CB_TX    = 4;
  localparam int CB_NOACK = 3;
  localparam int CB_RS    = 2;

  localparam int SB_RXNAK = 0;
  localparam int SB_FLAG  = 1;
  localparam int SB_BUSY  = 5;

  localparam logic [7:0] OWN_MASK = 8'hFE;
  localparam logic [7:0] DIV_MASK = 8'h3F;
  localparam logic [7:0] CTL_MASK = 8'hFC;
  localparam logic [7:0] NO_DATA  = 8'hFF;

  // A control write ends an open transfer when it disables, drops master or asks for a restart.
  function automatic logic ctl_ends_xfer(input logic open, input logic cur_en,
                                         input logic [7:0] w);
    return open && ((cur_en && !w[CB_EN]) || !w[CB_MST] || w[CB_RS]);
  endfunction

  // Value stored into control on a normal write; restart self-clears when it closed a transfer.
  function automatic logic [7:0] ctl_store(input logic open, input logic [7:0] w);
    logic [7:0] v;
    v = w & CTL_MASK;
    if (open) v[CB_RS] = 1'b0;
    return v;
  endfunction

  function automatic logic [7:0] status_byte(input logic rxnak, input logic flag,
                                             input logic busy);
    logic [7:0] s;
    s = 8'h00;
    s[SB_RXNAK] = rxnak;
    s[SB_FLAG]  = flag;
    s[SB_BUSY]  = busy;
    return s;
  endfunction

endpackage

// File: rtl/i2cm_decode.sv
module i2cm_decode #(
  parameter int AW     = 5,
  parameter int NR     = 5,
  parameter int STRIDE = 4
) (
  input  logic [AW-1:0] addr,
  output logic [NR-1:0] hit
);
  for (genvar i = 0; i < NR; i++) begin : g_slot
    localparam logic [AW-1:0] OFF_I = AW'(i * STRIDE);
    assign hit[i] = (addr == OFF_I);
  end
endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
  import i2cm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       launch,
  input  eng_op_e    op_in,
  input  logic [7:0] byte_in,
  input  logic       eng_ack,
  output logic       busy,
  output logic       done,
  output logic       eng_req,
  output eng_op_e    eng_op,
  output logic [7:0] eng_wbyte
);
  logic       busy_q;
  eng_op_e    op_q;
  logic [7:0] byte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      op_q   <= OP_START;
      byte_q <= 8'h00;
    end else if (!busy_q && launch) begin
      busy_q <= 1'b1;
      op_q   <= op_in;
      byte_q <= byte_in;
    end else if (busy_q && eng_ack) begin
      busy_q <= 1'b0;
    end
  end

  assign busy      = busy_q;
  assign done      = busy_q && eng_ack;
  assign eng_req   = busy_q;
  assign eng_op    = op_q;
  assign eng_wbyte = byte_q;

  p_req_held_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && !eng_ack) |=> (eng_req && $stable(eng_op) && $stable(eng_wbyte)));

  p_req_drops_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !eng_req);
endmodule

// File: rtl/i2cm_ctrl_front.sv
module i2cm_ctrl_front
  import i2cm_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_ready,
  output logic          irq,
  output logic          eng_req,
  output logic [1:0]    eng_op,
  output logic [7:0]    eng_wbyte,
  input  logic          eng_ack,
  input  logic          eng_nack,
  input  logic [7:0]    eng_rbyte
);
  logic [7:0] own_q, div_q, ctl_q, rd_q;
  logic       rxnak_q, flag_q, lnbusy_q, open_q;

  logic [NREG-1:0] hit;
  logic [7:0]      wb;
  logic            cur_en, cur_mst;
  logic            wr_ctl, wr_sts, wr_dat, rd_dat;

  i2cm_decode #(.AW(AW), .NR(NREG), .STRIDE(OFF_STRIDE)) u_dec (
    .addr(bus_addr), .hit(hit)
  );

  assign wb      = bus_wdata[7:0];
  assign cur_en  = ctl_q[CB_EN];
  assign cur_mst = ctl_q[CB_MST];
  assign wr_ctl  = bus_sel && bus_wr && hit[IX_CTL];
  assign wr_sts  = bus_sel && bus_wr && hit[IX_STS];
  assign wr_dat  = bus_sel && bus_wr && hit[IX_DAT];
  assign rd_dat  = bus_sel && !bus_wr && hit[IX_DAT];

  // Engine request selection for the access being presented
  logic       need_eng;
  eng_op_e    op_sel;
  logic [7:0] byte_sel;

  always_comb begin
    need_eng = 1'b0;
    op_sel   = OP_STOP;
    byte_sel = 8'h00;
    if (wr_ctl && ctl_ends_xfer(open_q, cur_en, wb)) begin
      need_eng = 1'b1;
    end else if (wr_dat && cur_en && cur_mst) begin
      need_eng = 1'b1;
      op_sel   = open_q ? OP_SEND : OP_START;
      byte_sel = wb;
    end else if (rd_dat && cur_mst && open_q && !ctl_q[CB_TX]) begin
      need_eng = 1'b1;
      op_sel   = OP_RECV;
    end
  end

  logic    seq_busy, seq_done, launch;
  eng_op_e seq_op;

  assign launch = bus_sel && !seq_busy && need_eng;

  i2cm_seq u_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch), .op_in(op_sel), .byte_in(byte_sel),
    .eng_ack(eng_ack), .busy(seq_busy), .done(seq_done), .eng_req(eng_req),
    .eng_op(seq_op), .eng_wbyte(eng_wbyte)
  );
  assign eng_op = seq_op;

  // Named events
  logic commit, ev_soft, ev_raise, ev_close_ctl;
  assign bus_ready    = seq_busy ? seq_done : !need_eng;
  assign commit       = bus_sel && bus_ready;
  assign ev_soft      = wr_ctl && cur_en && !wb[CB_EN];
  assign ev_close_ctl = open_q && (!wb[CB_MST] || wb[CB_RS]);
  assign ev_raise     = seq_done && !eng_nack && (seq_op != OP_STOP) &&
                        cur_en && ctl_q[CB_IE];

  // Read path
  logic [7:0] dat_view, rbyte;
  assign dat_view = (seq_done && !eng_nack) ? eng_rbyte : NO_DATA;

  always_comb begin
    rbyte = 8'h00;
    if (hit[IX_OWN]) rbyte = own_q;
    if (hit[IX_DIV]) rbyte = div_q;
    if (hit[IX_CTL]) rbyte = ctl_q;
    if (hit[IX_STS]) rbyte = status_byte(rxnak_q, flag_q, lnbusy_q);
    if (hit[IX_DAT]) rbyte = cur_mst ? dat_view : rd_q;
  end
  assign bus_rdata = DW'(rbyte);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= 8'h00; div_q <= 8'h00; ctl_q <= 8'h00; rd_q <= 8'h00;
      rxnak_q <= 1'b0; flag_q <= 1'b0; lnbusy_q <= 1'b0; open_q <= 1'b0;
    end else if (commit) begin
      if (ev_soft) begin
        div_q <= 8'h00; ctl_q <= 8'h00; rd_q <= 8'h00;
        rxnak_q <= 1'b0; flag_q <= 1'b0; lnbusy_q <= 1'b0; open_q <= 1'b0;
      end else begin
        if (bus_wr && hit[IX_OWN]) own_q <= wb & OWN_MASK;
        if (bus_wr && hit[IX_DIV]) div_q <= wb & DIV_MASK;
        if (wr_ctl) begin
          ctl_q    <= ctl_store(open_q, wb);
          lnbusy_q <= wb[CB_MST];
          if (ev_close_ctl) open_q <= 1'b0;
        end
        if (wr_sts && !wb[SB_FLAG]) flag_q <= 1'b0;
        if (wr_dat && seq_done) begin
          rxnak_q <= eng_nack;
          if (seq_op == OP_START) open_q <= !eng_nack;
          else if (eng_nack)      open_q <= 1'b0;
        end
        if (rd_dat && cur_mst) rd_q <= dat_view;
        if (ev_raise) flag_q <= 1'b1;
      end
    end
  end

  assign irq = flag_q;

  p_flag_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ctl_q[CB_EN] && ctl_q[CB_IE]));

  p_busy_master_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && wr_ctl && !ev_soft) |=> (lnbusy_q == $past(wb[CB_MST])));

  p_soft_keeps_own_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && ev_soft) |=> ((own_q == $past(own_q)) && (ctl_q == 8'h00) && !open_q && !irq));

  p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && wr_sts && !wb[SB_FLAG]) |=> !irq);

  p_master_close_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && wr_ctl && !wb[CB_MST]) |=> (!open_q && !lnbusy_q));

  p_no_req_disabled_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(eng_req) && (eng_op == 2'd0 || eng_op == 2'd1)) |-> $past(ctl_q[CB_EN]));

  p_ready_wait_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && !eng_ack) |-> !bus_ready);
endmodule

// File: tb/i2cm_ctrl_front_tb.sv
`timescale 1ns/1ps
module i2cm_ctrl_front_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_ready, irq, eng_req;
  logic [1:0]  eng_op;
  logic [7:0]  eng_wbyte;
  logic        eng_ack = 1'b0, eng_nack = 1'b0;
  logic [7:0]  eng_rbyte = 8'h00;

  int checks = 0, errors = 0;
  bit done_flag = 0;

  // engine model configuration and log
  logic       nack_cfg = 1'b0;
  logic [7:0] rb_cfg = 8'h00;
  int         req_cnt = 0, dly = 0;
  logic [1:0] last_op = 2'd0;
  logic [7:0] last_byte = 8'h00;

  always #10 clk = ~clk;

  i2cm_ctrl_front u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready), .irq(irq),
    .eng_req(eng_req), .eng_op(eng_op), .eng_wbyte(eng_wbyte), .eng_ack(eng_ack),
    .eng_nack(eng_nack), .eng_rbyte(eng_rbyte)
  );

  always @(posedge clk) begin
    eng_ack <= 1'b0;
    if (eng_req && !eng_ack) begin
      if (dly == 2) begin
        eng_ack   <= 1'b1;
        eng_nack  <= nack_cfg;
        eng_rbyte <= rb_cfg;
        dly       <= 0;
        req_cnt   <= req_cnt + 1;
        last_op   <= eng_op;
        last_byte <= eng_wbyte;
      end else begin
        dly <= dly + 1;
      end
    end
  end

  localparam logic [4:0] A_OWN = 5'h00, A_DIV = 5'h04, A_CTL = 5'h08,
                         A_STS = 5'h0C, A_DAT = 5'h10;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic acc(input bit wr, input logic [4:0] a, input logic [15:0] d,
                     output logic [15:0] rd, output int waits);
    waits = 0;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    #1;
    while (!bus_ready) begin
      waits++;
      @(negedge clk);
      #1;
    end
    rd = bus_rdata;
    @(posedge clk);
    #1 bus_sel = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    logic [15:0] r; int w;
    acc(1'b1, a, d, r, w);
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [7:0] exp, input string req);
    logic [15:0] r; int w;
    acc(1'b0, a, 16'h0, r, w);
    chk(r == {8'h00, exp}, req, r, exp);
  endtask

  task automatic t_reset;
    rd_chk(A_OWN, 8'h00, "R2 own");
    rd_chk(A_DIV, 8'h00, "R2 div");
    rd_chk(A_CTL, 8'h00, "R2 ctl");
    rd_chk(A_STS, 8'h00, "R2 sts");
    rd_chk(A_DAT, 8'h00, "R2 dat");
    @(negedge clk);
    chk(!irq && !eng_req, "R2 irq/req", {irq, eng_req}, 0);
  endtask

  task automatic t_decode;
    wr(A_OWN, 16'h00FF);
    rd_chk(A_OWN, 8'hFE, "R1 own mask");
    wr(A_DIV, 16'h01AB);
    rd_chk(A_DIV, 8'h2B, "R1 div mask");
    wr(5'h14, 16'h00FF);
    rd_chk(5'h14, 8'h00, "R1 bad offset");
    rd_chk(5'h02, 8'h00, "R1 unaligned offset");
  endtask

  task automatic t_busy;
    wr(A_CTL, 16'h00A0);
    rd_chk(A_STS, 8'h20, "R3 busy set");
    wr(A_CTL, 16'h0080);
    rd_chk(A_STS, 8'h00, "R3 busy clear");
  endtask

  task automatic t_start_send;
    logic [15:0] r; int w; int c0;
    wr(A_CTL, 16'h00F0);
    nack_cfg = 1'b0;
    c0 = req_cnt;
    acc(1'b1, A_DAT, 16'h0050, r, w);
    chk(req_cnt == c0 + 1 && last_op == 2'd0 && last_byte == 8'h50, "R5 start op",
        {last_op, last_byte}, {2'd0, 8'h50});
    chk(w > 0, "R13 ready held low", w, 1);
    chk(irq == 1'b1, "R5 flag on ack", irq, 1);
    rd_chk(A_STS, 8'h22, "R5 status");
    wr(A_STS, 16'h0002);
    rd_chk(A_STS, 8'h22, "R9 write 1 keeps");
    wr(A_STS, 16'h0000);
    rd_chk(A_STS, 8'h20, "R9 write 0 clears");
    chk(irq == 1'b0, "R9 irq low", irq, 0);
    wr(A_DAT, 16'h0033);
    chk(last_op == 2'd1 && last_byte == 8'h33 && irq, "R6 send ack", {last_op, last_byte}, {2'd1, 8'h33});
    wr(A_STS, 16'h0000);
  endtask

  task automatic t_nacks;
    nack_cfg = 1'b1;
    wr(A_DAT, 16'h0044);
    chk(last_op == 2'd1, "R6 send op", last_op, 1);
    rd_chk(A_STS, 8'h21, "R6 nack status");
    wr(A_DAT, 16'h0052);
    chk(last_op == 2'd0, "R6 closed after nack", last_op, 0);
    rd_chk(A_STS, 8'h21, "R5 addr nack status");
    nack_cfg = 1'b0;
    wr(A_DAT, 16'h0052);
    chk(last_op == 2'd0, "R5 still closed after addr nack", last_op, 0);
    rd_chk(A_STS, 8'h22, "R5 addr ack status");
    wr(A_STS, 16'h0000);
  endtask

  task automatic t_master_clear;
    wr(A_CTL, 16'h00C0);
    chk(last_op == 2'd3, "R10 stop op", last_op, 3);
    rd_chk(A_STS, 8'h00, "R10 busy cleared");
  endtask

  task automatic t_read;
    int c0;
    wr(A_CTL, 16'h00E0);
    wr(A_DAT, 16'h00A1);
    chk(last_op == 2'd0, "R7 start for read", last_op, 0);
    wr(A_STS, 16'h0000);
    rb_cfg = 8'h5A;
    rd_chk(A_DAT, 8'h5A, "R7 recv byte");
    chk(last_op == 2'd2 && irq, "R7 recv op+flag", {last_op, irq}, {2'd2, 1'b1});
    wr(A_STS, 16'h0000);
    nack_cfg = 1'b1;
    rd_chk(A_DAT, 8'hFF, "R7 recv fail");
    chk(!irq, "R7 no flag on fail", irq, 0);
    nack_cfg = 1'b0;
    wr(A_CTL, 16'h00F0);
    c0 = req_cnt;
    rd_chk(A_DAT, 8'hFF, "R7 tx set read");
    chk(req_cnt == c0, "R7 no request with tx", req_cnt, c0);
  endtask

  task automatic t_irq_gate;
    wr(A_CTL, 16'h00A0);
    wr(A_DAT, 16'h0011);
    chk(last_op == 2'd1 && !irq, "R8 no flag without ie", irq, 0);
    rd_chk(A_STS, 8'h20, "R8 status");
  endtask

  task automatic t_restart;
    int c0;
    wr(A_CTL, 16'h00E4);
    chk(last_op == 2'd3, "R11 stop on restart", last_op, 3);
    rd_chk(A_CTL, 8'hE0, "R11 self clear");
    c0 = req_cnt;
    wr(A_CTL, 16'h00E4);
    chk(req_cnt == c0, "R11 no stop when closed", req_cnt, c0);
    rd_chk(A_CTL, 8'hE4, "R11 kept when closed");
  endtask

  task automatic t_soft;
    wr(A_CTL, 16'h00E0);
    wr(A_DAT, 16'h0050);
    chk(irq == 1'b1, "R4 setup flag", irq, 1);
    wr(A_CTL, 16'h0000);
    chk(last_op == 2'd3, "R4 stop before reset", last_op, 3);
    rd_chk(A_OWN, 8'hFE, "R4 own kept");
    rd_chk(A_DIV, 8'h00, "R4 div cleared");
    rd_chk(A_CTL, 8'h00, "R4 ctl cleared");
    rd_chk(A_STS, 8'h00, "R4 sts cleared");
    chk(!irq, "R4 irq low", irq, 0);
  endtask

  task automatic t_disabled;
    logic [15:0] r; int w; int c0;
    wr(A_CTL, 16'h0020);
    c0 = req_cnt;
    acc(1'b1, A_DAT, 16'h0050, r, w);
    chk(req_cnt == c0 && w == 0, "R12 no request", req_cnt, c0);
    rd_chk(A_STS, 8'h20, "R12 status unchanged");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_decode();
    t_busy();
    t_start_send();
    t_nacks();
    t_master_clear();
    t_read();
    t_irq_gate();
    t_restart();
    t_soft();
    t_disabled();
    if (!done_flag) begin
      done_flag = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      checks++; errors++;
      $display("FAIL R13 watchdog actual=0x0 expected=0x1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule